// File: doc/BRIEF.md
# Pulse Width and Period Counter

This block times a digital signal in units of a base tick. The tick is the core clock divided by a ratio that software selects. The signal under test comes from one of three inputs: two pins and a comparator output that has already been made digital. It passes through a two-flop synchronizer and a noise filter before any edge is detected.

The measurement is one of four kinds:
- the width of a high level;
- the width of a low level;
- the time from one rising edge to the next;
- a combined mode that gives low width and period from the same cycle.

A finished measurement goes into the result registers and raises a sticky completion flag. The counter then rearms for the next measurement without software help. A count that runs past its range stops at all-ones and raises an overflow flag. Both flags clear through one clear input.

Configuration is changed only while `start` is low. Raising `start` runs the block. Dropping it stops counting and abandons any measurement in progress.

Top module: `pulse_meter`

## Requirements
- R1: After reset, `res_a` and `res_b` are zero and `done_flag` and `ovf_flag` are low.
- R2: One base tick lasts `div_sel`+1 core clocks, so the ratio covers 1 to 2^DIV_W. Every result is a count of base ticks: an input level held for N·(`div_sel`+1) core clocks measures N.
- R3: With `mode`=0 (high width), a rising edge opens the count and the next falling edge closes it. The high time in ticks goes to `res_a`.
- R4: With `mode`=1 (low width), a falling edge opens the count and the next rising edge closes it. The low time in ticks goes to `res_a`.
- R5: With `mode`=2 (period), the first rising edge opens the count. Each later rising edge stores the ticks since the previous rising edge in `res_a` and starts a new count.
- R6: With `mode`=3 (dual), each rising edge after the first stores the period in `res_b` and the low part of that period in `res_a`, so `res_a` never exceeds `res_b`.
- R7: `src_sel`=0 measures `pin_a`, 1 measures `pin_b`, and 2 or 3 measure `cmp_in`. Activity on an input that is not selected produces no result.
- R8: The filtered level follows the selected input only after FILT_LEN consecutive equal base-tick samples. A pulse shorter than FILT_LEN ticks gives no result and leaves the results unchanged. A pulse of exactly FILT_LEN ticks is measured.
- R9: Each completed measurement sets `done_flag`, which stays set until `irq_clr` is pulsed. A set and a clear in the same cycle leave the flag set. The block rearms after every completion, so back-to-back measurements each report.
- R10: A count that reaches all-ones holds there and sets `ovf_flag`. The saturated value is stored at the closing edge. `irq_clr` clears `ovf_flag`.
- R11: Dropping `start` abandons an open measurement. A later restart produces no result from it, and the previous results are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_a | input | 1 | First pin source |
| pin_b | input | 1 | Second pin source |
| cmp_in | input | 1 | Comparator output, already digital |
| src_sel | input | 2 | Source select: 0 pin_a, 1 pin_b, 2 or 3 cmp_in |
| mode | input | 2 | 0 high width, 1 low width, 2 period, 3 low width and period |
| div_sel | input | DIV_W | Base tick ratio minus one |
| start | input | 1 | Run enable; low stops and abandons the current measurement |
| irq_clr | input | 1 | One-cycle pulse that clears done_flag and ovf_flag |
| res_a | output | CNT_W | Width or period result; low width in dual mode |
| res_b | output | CNT_W | Period result in dual mode |
| done_flag | output | 1 | Sticky completion flag |
| ovf_flag | output | 1 | Sticky count saturation flag |

## Verification
The bench builds the block with CNT_W=8, DIV_W=4 and FILT_LEN=3. The narrow counter lets a single 300-tick pulse drive the count into saturation. The 4-bit divider lets ratios of 1, 2, 4 and 16 be tried, which covers both ends of the range. A filter length of three gives a two-tick pulse that must be dropped and a three-tick pulse that must be measured. Patterns are built in whole base ticks, so each expected count is exact whatever the divider phase.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MEAS_HIGH   = 2'd0,
    MEAS_LOW    = 2'd1,
    MEAS_PERIOD = 2'd2,
    MEAS_DUAL   = 2'd3
  } meas_mode_e;

  typedef enum logic [1:0] {
    SRC_A    = 2'd0,
    SRC_B    = 2'd1,
    SRC_CMP  = 2'd2,
    SRC_CMP2 = 2'd3
  } src_e;
endpackage

// File: rtl/pmc_tick_gen.sv
module pmc_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  assign tick = run && (phase == div_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= '0;
    else if (!run || tick)   phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  // R2: with a ratio above one, two ticks never come back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0) |=> !tick);
endmodule

// File: rtl/pmc_input_cond.sv
module pmc_input_cond
  import pmc_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       cmp_in,
  input  logic [1:0] src_sel,
  output logic       level
);
  localparam int AW = $clog2(FILT_LEN + 1);
  localparam logic [AW-1:0] AGREE_LAST = AW'(FILT_LEN - 1);

  logic       picked;
  logic [1:0] sync_q;
  logic [AW-1:0] agree;
  logic       raw;

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_A:   picked = pin_a;
      SRC_B:   picked = pin_b;
      default: picked = cmp_in;
    endcase
  end

  assign raw = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], picked};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      agree <= '0;
    end else if (!run) begin
      level <= 1'b0;
      agree <= '0;
    end else if (tick) begin
      if (raw == level)             agree <= '0;
      else if (agree == AGREE_LAST) begin
        level <= raw;
        agree <= '0;
      end else                      agree <= agree + 1'b1;
    end
  end

  // R8: the filtered level only moves on a base tick
  p_level_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(level));
endmodule

// File: rtl/pmc_core.sv
module pmc_core
  import pmc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             level,
  input  logic [1:0]       mode,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] res_a,
  output logic [CNT_W-1:0] res_b,
  output logic             done_flag,
  output logic             ovf_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] low_part(input logic [CNT_W-1:0] per,
                                                input logic [CNT_W-1:0] hi);
    return per - hi;
  endfunction

  meas_mode_e      mm;
  logic            prev, busy;
  logic [CNT_W-1:0] cnt, mark;
  logic            rise_ev, fall_ev, open_ev, close_ev, latch, restart, sat_hit;

  assign mm      = meas_mode_e'(mode);
  assign rise_ev = tick && level && !prev;
  assign fall_ev = tick && !level && prev;

  always_comb begin
    unique case (mm)
      MEAS_HIGH: begin open_ev = rise_ev; close_ev = fall_ev; end
      MEAS_LOW:  begin open_ev = fall_ev; close_ev = rise_ev; end
      default:   begin open_ev = rise_ev; close_ev = rise_ev; end
    endcase
  end

  assign latch   = close_ev && busy;
  assign restart = open_ev && (!busy || latch);
  assign sat_hit = tick && busy && (cnt == CNT_MAX) && !latch && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0; busy <= 1'b0; cnt <= '0; mark <= '0;
    end else if (!run) begin
      prev <= 1'b0; busy <= 1'b0; cnt <= '0; mark <= '0;
    end else if (tick) begin
      prev <= level;
      if (restart) begin
        busy <= 1'b1;
        cnt  <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (latch) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= sat_inc(cnt);
        if (fall_ev && mm == MEAS_DUAL) mark <= cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_a <= '0; res_b <= '0;
    end else if (latch) begin
      if (mm == MEAS_DUAL) begin
        res_a <= low_part(cnt, mark);
        res_b <= cnt;
      end else begin
        res_a <= cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0; ovf_flag <= 1'b0;
    end else begin
      if (latch)        done_flag <= 1'b1;
      else if (irq_clr) done_flag <= 1'b0;
      if (sat_hit)      ovf_flag <= 1'b1;
      else if (irq_clr) ovf_flag <= 1'b0;
    end
  end

  // R9: a completion always leaves the flag set
  p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> done_flag);
  // R10: the count holds at all-ones until an edge resolves it
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && busy && cnt == CNT_MAX && !latch && !restart) |=> (cnt == CNT_MAX));
  // R10: overflow rises only from a saturated count
  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt) == CNT_MAX));
  // R6: the low part never exceeds its period
  p_dual_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && mm == MEAS_DUAL) |=> (res_a <= res_b));
  // R11: stopping clears the open count
  p_stop_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !busy));
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter #(
  parameter int CNT_W    = 16,
  parameter int DIV_W    = 4,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             cmp_in,
  input  logic [1:0]       src_sel,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             start,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] res_a,
  output logic [CNT_W-1:0] res_b,
  output logic             done_flag,
  output logic             ovf_flag
);
  logic tick;
  logic level;

  pmc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(start), .div_sel(div_sel), .tick(tick)
  );

  pmc_input_cond #(.FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst_n(rst_n), .run(start), .tick(tick),
    .pin_a(pin_a), .pin_b(pin_b), .cmp_in(cmp_in), .src_sel(src_sel),
    .level(level)
  );

  pmc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(start), .tick(tick), .level(level),
    .mode(mode), .irq_clr(irq_clr),
    .res_a(res_a), .res_b(res_b), .done_flag(done_flag), .ovf_flag(ovf_flag)
  );
endmodule

// File: tb/pulse_meter_test.sv
`timescale 1ns/1ps
module pulse_meter_test;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int FL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 1'b0, pin_b = 1'b0, cmp_in = 1'b0;
  logic [1:0] src_sel = '0, mode = '0;
  logic [DW-1:0] div_sel = '0;
  logic start = 1'b0, irq_clr = 1'b0;
  logic [CW-1:0] res_a, res_b;
  logic done_flag, ovf_flag;

  int compared = 0, mismatched = 0;
  int cur_ratio = 1;
  int cur_src = 0;
  bit ended = 0;

  typedef struct {
    string         req;
    logic [CW-1:0] a;
    logic [CW-1:0] b;
    bit            use_b;
    bit            ovf;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  pulse_meter #(.CNT_W(CW), .DIV_W(DW), .FILT_LEN(FL)) uut (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .cmp_in(cmp_in),
    .src_sel(src_sel), .mode(mode), .div_sel(div_sel), .start(start),
    .irq_clr(irq_clr), .res_a(res_a), .res_b(res_b),
    .done_flag(done_flag), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input string req, input int a, input int b, input bit use_b, input bit ovf);
    exp_t e;
    e.req = req; e.a = CW'(a); e.b = CW'(b); e.use_b = use_b; e.ovf = ovf;
    sb.push_back(e);
  endtask

  // hold one source at a level for a whole number of base ticks
  task automatic drive(input int which, input logic v, input int ticks);
    case (which)
      0:       pin_a = v;
      1:       pin_b = v;
      default: cmp_in = v;
    endcase
    repeat (ticks * cur_ratio) @(negedge clk);
  endtask

  task automatic setup(input int m, input int s, input int d);
    @(negedge clk);
    start = 1'b0;
    pin_a = 1'b0; pin_b = 1'b0; cmp_in = 1'b0;
    mode = 2'(m); src_sel = 2'(s); div_sel = DW'(d);
    cur_ratio = d + 1; cur_src = (s >= 2) ? 2 : s;
    repeat (4) @(negedge clk);
    start = 1'b1;
    repeat (2 * cur_ratio) @(negedge clk);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (sb.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (sb.size() != 0) begin
      check("R9 missing completion", sb.size(), 0);
      sb.delete();
    end
    repeat (4) @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: compare every completion with the head of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (irq_clr) irq_clr = 1'b0;
      else if (rst_n && done_flag) begin
        if (sb.size() == 0) begin
          check("R9 unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.req, " res_a"}, int'(res_a), int'(e.a));
          if (e.use_b) check({e.req, " res_b"}, int'(res_b), int'(e.b));
          check({e.req, " ovf_flag"}, int'(ovf_flag), int'(e.ovf));
        end
        irq_clr = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 res_a", int'(res_a), 0);
    check("R1 res_b", int'(res_b), 0);
    check("R1 done_flag", int'(done_flag), 0);
    check("R1 ovf_flag", int'(ovf_flag), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 high width at ratio 4 (R2), then R9 back-to-back rearm
    setup(0, 0, 3);
    push("R3 high width", 7, 0, 0, 0);
    push("R9 rearm", 4, 0, 0, 0);
    drive(0, 0, 5); drive(0, 1, 7); drive(0, 0, 5);
    drive(0, 1, 4); drive(0, 0, 8);
    drain();

    // R5 period at ratio 1
    setup(2, 0, 0);
    push("R5 period", 10, 0, 0, 0);
    push("R5 period", 8, 0, 0, 0);
    drive(0, 0, 5); drive(0, 1, 4); drive(0, 0, 6); drive(0, 1, 3);
    drive(0, 0, 5); drive(0, 1, 3); drive(0, 0, 8);
    drain();

    // R4 low width at ratio 16 (R2 upper end)
    setup(1, 0, 15);
    push("R4 low width", 9, 0, 0, 0);
    drive(0, 0, 5); drive(0, 1, 4); drive(0, 0, 9); drive(0, 1, 6);
    drain();

    // R6 dual mode from the comparator input (R7 source 2) at ratio 2
    setup(3, 2, 1);
    push("R6 dual", 7, 13, 1, 0);
    push("R6 dual", 3, 8, 1, 0);
    drive(2, 0, 5); drive(2, 1, 6); drive(2, 0, 7); drive(2, 1, 5);
    drive(2, 0, 3); drive(2, 1, 4); drive(2, 0, 8);
    drain();

    // R7 source select: pin_a ignored while pin_b is chosen
    setup(0, 1, 0);
    drive(0, 1, 8); drive(0, 0, 12);
    check("R7 unselected done_flag", int'(done_flag), 0);
    check("R7 unselected res_a", int'(res_a), 3);
    push("R7 pin_b", 6, 0, 0, 0);
    drive(1, 0, 5); drive(1, 1, 6); drive(1, 0, 8);
    drain();

    // R8 filter: two ticks dropped, three ticks measured
    setup(0, 0, 0);
    drive(0, 0, 5); drive(0, 1, 2); drive(0, 0, 12);
    check("R8 short pulse done_flag", int'(done_flag), 0);
    check("R8 short pulse res_a", int'(res_a), 6);
    push("R8 minimum pulse", 3, 0, 0, 0);
    drive(0, 1, 3); drive(0, 0, 8);
    drain();

    // R10 saturation and overflow flag
    setup(0, 0, 0);
    push("R10 saturated", 255, 0, 0, 1);
    drive(0, 0, 5); drive(0, 1, 300); drive(0, 0, 8);
    drain();
    check("R10 ovf cleared", int'(ovf_flag), 0);

    // R11 abandon an open measurement
    setup(0, 0, 0);
    drive(0, 0, 5); drive(0, 1, 5);
    start = 1'b0; pin_a = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1;
    repeat (30) @(negedge clk);
    check("R11 done_flag", int'(done_flag), 0);
    check("R11 res_a kept", int'(res_a), 255);
    start = 1'b0;
    repeat (4) @(negedge clk);

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule